// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This block is a small execution core whose arithmetic operands all live in a hardware operand stack. Instructions carry an opcode and, for memory instructions, a word address. The core understands three kinds of work:

- **Load-to-stack** fetches a word from data memory and places it on top of the stack.
- **Store-from-stack** removes the top word and writes it to data memory.
- **Add** carries no operand field at all. It consumes the top two stack words and leaves their sum in their place.

All memory traffic passes through the load and store instructions.

A host presents one instruction at a time with `instr_valid` while `instr_ready` is high. Every instruction that the core accepts with a non-zero opcode ends with a one-cycle `done` pulse. If the instruction would overflow or underflow the stack, `err` pulses together with `done`. In that case nothing in the stack or in memory changes.

The data memory is word-addressable and has a one-cycle read latency. A write takes effect on the clock edge at which the write enable is sampled high.

Top module: `stack_core`

## Requirements
- R1: After synchronous reset the stack is empty (`depth_cnt`=0, `tos_data`=0), `done` and `err` are low, `instr_ready` is high, and neither memory enable is asserted.
- R2: A load-to-stack (opcode 2'b01) reads memory at `instr_addr` and pushes that word. `done` rises on the second clock edge after acceptance, and the depth grows by one.
- R3: A store-from-stack (opcode 2'b10) writes the top word to memory at `instr_addr` and removes it. The write and the `done` pulse happen on the second clock edge after acceptance.
- R4: An add (opcode 2'b11) replaces the top two words with their sum, so the depth shrinks by one. `done` rises on the first clock edge after acceptance.
- R5: The sum wraps modulo 2^DATA_W and no carry is reported.
- R6: A load-to-stack issued when `depth_cnt`=DEPTH pulses `err` with `done` after one edge. It issues no memory read and leaves the stack unchanged.
- R7: A store-from-stack issued on an empty stack pulses `err` with `done` after one edge. It issues no memory write and leaves the stack unchanged.
- R8: An add issued with fewer than two words on the stack pulses `err` with `done` after one edge and leaves the stack unchanged.
- R9: The sequence load A, load B, add, store C leaves the wrapped sum of the words at A and B in location C and returns the stack to its prior depth.
- R10: While a memory access is pending, `instr_ready` is low and no new instruction is taken.
- R11: Opcode 2'b00 is accepted but does nothing: no `done`, no memory access, and no change to the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present |
| instr_op | input | 2 | Opcode: 00 none, 01 load, 10 store, 11 add |
| instr_addr | input | ADDR_W | Word address for load and store |
| instr_ready | output | 1 | Core can take an instruction |
| mem_addr | output | ADDR_W | Data memory address |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_data | input | DATA_W | Read word, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | DATA_W | Word to write |
| done | output | 1 | Instruction completion pulse |
| err | output | 1 | Overflow or underflow, pulses with done |
| depth_cnt | output | $clog2(DEPTH+1) | Current stack occupancy |
| tos_data | output | DATA_W | Top word, zero when empty |

## Verification
The bench targets the stack boundaries.

| Case | What a faulty design would do |
|---|---|
| Add on an empty stack and on a single-entry stack | Read stale slots and count below zero |
| Store on an empty stack | Corrupt a sentinel word in memory |
| Load on a full stack | Wrap the pointer onto the bottom entry, or still request a memory read |

It also checks a sum that crosses 2^16, which would expose a carry leaking into the result. It measures the exact latency of each instruction kind, so a core that signals completion early or late is caught. Finally, it issues the no-operation opcode and checks that this produces no completion pulse and no stack change.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_ADD   = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } stk_state_e;

    // Operation request from the sequencer to the storage.
    typedef struct packed {
        logic push;
        logic pop;
        logic fold;
    } stk_cmd_t;

    // Modulo addition; carry out is discarded by the result width.
    function automatic logic [31:0] wrap_add(input logic [31:0] a,
                                             input logic [31:0] b);
        return a + b;
    endfunction

endpackage

// File: rtl/stk_lifo.sv
module stk_lifo
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_cmd_t          cmd,
    input  logic [DATA_W-1:0] push_val,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second
);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  sec_idx;
    logic [IDX_W-1:0]  free_idx;
    logic [31:0]       sum_w;

    assign top_idx  = IDX_W'(count - CNT_W'(1));
    assign sec_idx  = IDX_W'(count - CNT_W'(2));
    assign free_idx = IDX_W'(count);

    assign top    = (count == '0)        ? '0 : slots[top_idx];
    assign second = (count < CNT_W'(2)) ? '0 : slots[sec_idx];
    assign sum_w  = wrap_add(32'(top), 32'(second));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (cmd.push) begin
            slots[free_idx] <= push_val;
            count           <= count + CNT_W'(1);
        end else if (cmd.pop) begin
            count <= count - CNT_W'(1);
        end else if (cmd.fold) begin
            slots[sec_idx] <= sum_w[DATA_W-1:0];
            count          <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [1:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic              instr_ready,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] top,
    output stk_cmd_t          cmd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              done,
    output logic              err
);

    stk_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              is_full;
    logic              load_ok;
    logic              store_ok;
    logic              add_ok;
    logic              bad;
    stk_op_e           op;

    assign op          = stk_op_e'(instr_op);
    assign instr_ready = (state == ST_IDLE);
    assign accept      = instr_valid && instr_ready;
    assign is_full     = (count == CNT_W'(DEPTH));

    assign load_ok  = accept && (op == OP_LOAD)  && !is_full;
    assign store_ok = accept && (op == OP_STORE) && (count != '0);
    assign add_ok   = accept && (op == OP_ADD)   && (count >= CNT_W'(2));
    assign bad      = accept && (op != OP_NONE) && !load_ok && !store_ok && !add_ok;

    assign mem_rd_en   = load_ok;
    assign mem_wr_en   = (state == ST_WRITE);
    assign mem_addr    = (state == ST_IDLE) ? instr_addr : addr_q;
    assign mem_wr_data = top;

    always_comb begin
        cmd      = '0;
        cmd.push = (state == ST_READ);
        cmd.pop  = (state == ST_WRITE);
        cmd.fold = add_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= add_ok || bad || (state != ST_IDLE);
            err  <= bad;
            unique case (state)
                ST_IDLE: begin
                    if (load_ok) begin
                        state <= ST_READ;
                    end else if (store_ok) begin
                        state  <= ST_WRITE;
                        addr_q <= instr_addr;
                    end
                end
                ST_READ:  state <= ST_IDLE;
                ST_WRITE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stack_core.sv
module stack_core
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [1:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    output logic              instr_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  depth_cnt,
    output logic [DATA_W-1:0] tos_data
);

    stk_cmd_t          cmd;
    logic [DATA_W-1:0] second;

    stk_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .instr_ready (instr_ready),
        .count       (depth_cnt),
        .top         (tos_data),
        .cmd         (cmd),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data),
        .done        (done),
        .err         (err)
    );

    stk_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lifo (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .push_val (mem_rd_data),
        .count    (depth_cnt),
        .top      (tos_data),
        .second   (second)
    );

endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_ready,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              done,
    input logic              err,
    input logic [CNT_W-1:0]  depth_cnt
);

    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (depth_cnt == '0 && !done && !err)) else $error("reset state"); // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> (!done ##1 (done && !err))) else $error("load latency"); // R2

    AST_WRITE_DONE: assert property (@(posedge clk) disable iff (rst) mem_wr_en |=> (done && !err)) else $error("store completion"); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) depth_cnt <= CNT_W'(DEPTH)) else $error("depth exceeds limit"); // R6

    AST_READ_NOT_FULL: assert property (@(posedge clk) disable iff (rst) mem_rd_en |-> depth_cnt < CNT_W'(DEPTH)) else $error("read on full"); // R6

    AST_WRITE_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> depth_cnt != '0) else $error("write on empty"); // R7

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst) err |-> done) else $error("err without done"); // R8

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst) !(mem_rd_en && mem_wr_en)) else $error("read and write together"); // R10

    AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> !instr_ready) else $error("ready while reading"); // R10

endmodule

bind stack_core stack_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_ready (instr_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .done        (done),
    .err         (err),
    .depth_cnt   (depth_cnt)
);

// File: tb/stack_core_bench.sv
module stack_core_bench;

    localparam int DW = 16;
    localparam int AW = 12;
    localparam int DP = 8;
    localparam int CW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          instr_valid;
    logic [1:0]    instr_op;
    logic [AW-1:0] instr_addr;
    logic          instr_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en;
    logic [DW-1:0] mem_rd_data;
    logic          mem_wr_en;
    logic [DW-1:0] mem_wr_data;
    logic          done;
    logic          err;
    logic [CW-1:0] depth_cnt;
    logic [DW-1:0] tos_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit in_flight = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    int model[$];
    logic [DW-1:0] bmem [0:(1<<AW)-1];

    always #5 clk = ~clk;

    stack_core #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DP)) u_stack_core (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_addr(instr_addr), .instr_ready(instr_ready), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .done(done), .err(err),
        .depth_cnt(depth_cnt), .tos_data(tos_data)
    );

    always @(posedge clk) begin
        if (mem_wr_en) begin bmem[mem_addr] <= mem_wr_data; wr_seen <= wr_seen + 1; end
        if (mem_rd_en) begin mem_rd_data <= bmem[mem_addr]; rd_seen <= rd_seen + 1; end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_top();
        return (model.size() == 0) ? 0 : model[model.size()-1];
    endfunction

    // Per-clock comparison against the reference model between instructions.
    always @(negedge clk) begin
        if (!rst && !in_flight && !finished) begin
            check(int'(depth_cnt) == model.size(), "R1 depth idle", depth_cnt, model.size());
            check(int'(tos_data) == model_top(), "R4 top idle", tos_data, model_top());
            check(done == 1'b0, "R11 no stray done", done, 0);
        end
    end

    // Caller is at a negedge.
    task automatic exec(input logic [1:0] op, input logic [AW-1:0] a);
        bit exp_err;
        int exp_lat;
        int n;
        int rd0, wr0, x, y;
        logic [DW-1:0] keep;
        string tag;
        exp_err = (op == 2'b01 && model.size() == DP) ||
                  (op == 2'b10 && model.size() == 0) ||
                  (op == 2'b11 && model.size() < 2);
        exp_lat = (!exp_err && (op == 2'b01 || op == 2'b10)) ? 2 : 1;
        tag = (op == 2'b01) ? (exp_err ? "R6" : "R2") :
              (op == 2'b10) ? (exp_err ? "R7" : "R3") : (exp_err ? "R8" : "R4");
        keep = bmem[a];
        rd0 = rd_seen; wr0 = wr_seen;
        in_flight = 1;
        instr_valid = 1; instr_op = op; instr_addr = a;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 0;
        n = 1;
        if (exp_lat == 2) check(instr_ready == 1'b0, "R10 busy", instr_ready, 0);
        while (!done && n < 6) begin @(negedge clk); n++; end
        check(done == 1'b1, {tag, " done"}, done, 1);
        check(n == exp_lat, {tag, " latency"}, n, exp_lat);
        check(err == exp_err, {tag, " err"}, err, exp_err);
        if (!exp_err) begin
            case (op)
                2'b01: model.push_back(int'(bmem[a]));
                2'b10: begin
                    x = model.pop_back();
                    check(int'(bmem[a]) == x, "R3 stored word", bmem[a], x);
                end
                default: begin
                    x = model.pop_back(); y = model.pop_back();
                    model.push_back((x + y) & 16'hFFFF);
                end
            endcase
        end else begin
            check(bmem[a] == keep, {tag, " memory kept"}, bmem[a], keep);
        end
        check(rd_seen - rd0 == ((!exp_err && op == 2'b01) ? 1 : 0), {tag, " reads"}, rd_seen - rd0, 0);
        check(wr_seen - wr0 == ((!exp_err && op == 2'b10) ? 1 : 0), {tag, " writes"}, wr_seen - wr0, 0);
        @(negedge clk);
        in_flight = 0;
        check(int'(depth_cnt) == model.size(), {tag, " depth"}, depth_cnt, model.size());
        check(int'(tos_data) == model_top(), {tag, " top"}, tos_data, model_top());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) bmem[i] = 16'(i * 37 + 5);
        rst = 1; instr_valid = 0; instr_op = 0; instr_addr = 0;
        in_flight = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(depth_cnt == 0 && tos_data == 0, "R1 empty", depth_cnt, 0);
        check(!done && !err && instr_ready, "R1 flags", {done, err, instr_ready}, 1);
        check(!mem_rd_en && !mem_wr_en, "R1 mem idle", {mem_rd_en, mem_wr_en}, 0);
        rst = 0;
        @(negedge clk);
        in_flight = 0;

        exec(2'b11, 12'h000);   // R8 add empty
        bmem[12'h0FF] = 16'hBEEF;
        exec(2'b10, 12'h0FF);   // R7 store empty
        check(bmem[12'h0FF] == 16'hBEEF, "R7 sentinel", bmem[12'h0FF], 16'hBEEF);

        // R9 program: load A, load B, add, store C
        bmem[12'h010] = 16'h1234; bmem[12'h020] = 16'h0F0F;
        exec(2'b01, 12'h010);
        exec(2'b11, 12'h000);   // R8 add with one entry
        exec(2'b01, 12'h020);
        exec(2'b11, 12'h000);
        exec(2'b10, 12'h030);
        check(bmem[12'h030] == 16'h2143, "R9 C=A+B", bmem[12'h030], 16'h2143);

        // R5 wrap
        bmem[12'h040] = 16'hFFF0; bmem[12'h041] = 16'h0025;
        exec(2'b01, 12'h040);
        exec(2'b01, 12'h041);
        exec(2'b11, 12'h000);
        check(tos_data == 16'h0015, "R5 wrap", tos_data, 16'h0015);
        exec(2'b10, 12'h042);

        // R11 opcode none
        in_flight = 1;
        instr_valid = 1; instr_op = 2'b00; instr_addr = 12'h050;
        @(posedge clk); @(negedge clk); instr_valid = 0;
        for (int k = 0; k < 3; k++) begin
            check(!done && !mem_rd_en && !mem_wr_en, "R11 none idle", done, 0);
            @(negedge clk);
        end
        check(depth_cnt == 0, "R11 depth kept", depth_cnt, 0);
        in_flight = 0;

        // R6 fill then overflow
        for (int k = 0; k < DP; k++) exec(2'b01, AW'(12'h100 + k));
        check(depth_cnt == DP, "R6 full", depth_cnt, DP);
        exec(2'b01, 12'h200);
        check(depth_cnt == DP, "R6 still full", depth_cnt, DP);

        // fold chain and drain
        exec(2'b11, 12'h000);
        exec(2'b11, 12'h000);
        for (int k = 0; k < DP - 2; k++) exec(2'b10, AW'(12'h300 + k));
        exec(2'b10, 12'h310);   // R7 underflow again

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule